// File: doc/BRIEF.md
# Serial Word Memory Slave

This block is the device side of a three-wire serial word memory, built to sit inside a chip that samples a slow external serial bus with one fast system clock. The host pulls the active-low select, clocks in a 32-bit instruction frame with the serial clock, and either reads 16-bit words back from a 256-word array or commits a write. A write-enable latch protects the array. A write runs a self-timed program cycle whose length is a parameter counted in system-clock cycles. While the cycle runs, the block reports busy on a ready pin, and it can also report busy on the data output.

The serial clock, select, data input and write-control input are resynchronised into the system clock domain and edge-detected there. Data is captured on each rising serial-clock edge. Output bits change after falling edges. The array is written through a single registered write port and read through a registered read port, so it maps onto an inferred block RAM. A separate per-word valid vector makes every word read as all ones after reset.

Top module: `serial_word_mem`

## Requirements
- R1: After reset, rdy is 1, sdo_oe is 0, and every word reads back as 16'hFFFF.
- R2: A frame counts only if its first four bits, in time order, are 1,0,1,0. Any other start pattern makes the rest of the frame up to select release have no effect, including a write-enable opcode.
- R3: After the start bits come four opcode bits in time order (READ 1000, WRITE 0100, WEN 0011, WDS 0000), then an 8-bit address, least significant bit first. For READ, sdo_oe stays 0 through the 16th rising clock. Bit 0 of the addressed word is driven at the 16th falling edge, and the following bits come one per falling edge, least significant first. Raising select returns sdo_oe to 0.
- R4: Clocking on through a READ emits the word at the next address every 16 clocks. The address wraps from 255 to 0.
- R5: The write-enable latch is cleared by reset. A WRITE frame issued while the latch is clear leaves the array and rdy unchanged.
- R6: WEN sets the latch and WDS clears it once the 16th bit has been received. For both, the address value, any clocks after the 16th, and the level of wr_ctl have no effect.
- R7: For an accepted WRITE, the 16 data bits follow the address, least significant bit first. rdy drops a few system clocks after the 32nd rising clock and stays low for PROG_CYCLES cycles. After that the word holds the new data.
- R8: If select rises before the 32nd rising clock, or wr_ctl is high at any point during a WRITE frame, the write is cancelled. rdy stays 1 and the word keeps its old value.
- R9: If wr_ctl is high while busy, the program cycle ends at once, rdy returns to 1, and the word reads back as 16'h0000.
- R10: No frame is started while busy. After a frame ends, further clocks under the same select have no effect until select has been high once.
- R11: After a write, a select fall while the serial clock is low makes sdo_oe 1 and sdo show the ready state (0 = busy, 1 = ready) until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| wr_ctl | input | 1 | Write control; high blocks or aborts programming |
| sdo | output | 1 | Serial data or status out |
| sdo_oe | output | 1 | Output enable for sdo (0 = high impedance) |
| rdy | output | 1 | 1 = ready, 0 = program cycle running |

## Verification
The hardest state to reach from the ports is a program cycle that is still running while the host does something else: a second full WRITE frame, a status query on sdo, or a wr_ctl abort. The bench overrides the program-cycle length so that it is longer than a complete frame plus the select gaps. It then issues the second frame or the wr_ctl pulse before rdy returns, and reads the targeted words afterwards to confirm which writes took effect. Cancel cases are reached by cutting a WRITE frame short halfway through its data bits, or by pulsing wr_ctl for one serial clock inside the data bits.

// File: rtl/swm_pkg.sv
package swm_pkg;
  // Frame bits are stored at the index of their arrival; these constants
  // are the packed values of the start and opcode fields seen that way.
  localparam logic [3:0] START_PAT = 4'b0101;
  localparam logic [3:0] OP_READ   = 4'b0001;
  localparam logic [3:0] OP_WRITE  = 4'b0010;
  localparam logic [3:0] OP_WEN    = 4'b1100;
  localparam logic [3:0] OP_WDS    = 4'b0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_READ,
    ST_HOLD
  } fstate_t;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/swm_store.sv
module swm_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (we) valid[waddr] <= 1'b1;
      rvalid_q <= valid[raddr];
    end
  end

  // Unwritten words read as all ones.
  assign rword = rvalid_q ? rdata_q : '1;
endmodule

// File: rtl/swm_prog_timer.sv
module swm_prog_timer #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] cnt;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        cnt    <= TW'(PROG_CYCLES - 1);
        p_addr <= addr;
        p_data <= data;
      end else if (busy) begin
        if (abort) begin
          busy  <= 1'b0;
          we    <= 1'b1;
          waddr <= p_addr;
          wdata <= '0;
        end else if (cnt == '0) begin
          busy  <= 1'b0;
          we    <= 1'b1;
          waddr <= p_addr;
          wdata <= p_data;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swm_frame.sv
module swm_frame
  import swm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          sel_rise,
  input  logic          sel_fall,
  input  logic          sk_lvl,
  input  logic          di_lvl,
  input  logic          wc_lvl,
  input  logic          busy,
  input  logic [DW-1:0] rword,
  output logic [AW-1:0] rd_addr,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          do_val,
  output logic          do_oe,
  output logic          status_on
);
  localparam int HLEN = 8 + AW;
  localparam int FLEN = HLEN + DW;
  localparam int CW   = $clog2(FLEN + 1);
  localparam int IW   = $clog2(FLEN);
  localparam int BW   = $clog2(DW);

  fstate_t         state;
  logic [CW-1:0]   cnt;
  logic [FLEN-1:0] frame;
  logic            bit_done;
  logic            wc_seen;
  logic            wel;
  logic            post_write;
  logic [BW-1:0]   bitpos;
  logic [DW-1:0]   osh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      frame      <= '0;
      bit_done   <= 1'b0;
      wc_seen    <= 1'b0;
      wel        <= 1'b0;
      post_write <= 1'b0;
      bitpos     <= '0;
      osh        <= '0;
      rd_addr    <= '0;
      wr_start   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      do_val     <= 1'b0;
      do_oe      <= 1'b0;
      status_on  <= 1'b0;
    end else begin
      wr_start <= 1'b0;
      bit_done <= 1'b0;
      if (sel_rise) begin
        state     <= ST_IDLE;
        do_oe     <= 1'b0;
        status_on <= 1'b0;
      end else if (sel_fall) begin
        if (!sk_lvl && post_write) status_on <= 1'b1;
        if (!busy) begin
          state      <= ST_SHIFT;
          cnt        <= '0;
          wc_seen    <= 1'b0;
          post_write <= 1'b0;
        end
      end else begin
        case (state)
          ST_SHIFT: begin
            if (wc_lvl) wc_seen <= 1'b1;
            if (sk_rise) begin
              frame[cnt[IW-1:0]] <= di_lvl;
              cnt       <= cnt + 1'b1;
              bit_done  <= 1'b1;
              status_on <= 1'b0;
            end else if (bit_done) begin
              if (cnt == CW'(4)) begin
                if (frame[3:0] != START_PAT) state <= ST_HOLD;
              end else if (cnt == CW'(HLEN)) begin
                case (frame[7:4])
                  OP_READ: begin
                    state   <= ST_READ;
                    rd_addr <= frame[HLEN-1:8];
                    bitpos  <= '0;
                  end
                  OP_WEN: begin
                    wel   <= 1'b1;
                    state <= ST_HOLD;
                  end
                  OP_WDS: begin
                    wel   <= 1'b0;
                    state <= ST_HOLD;
                  end
                  OP_WRITE: begin
                    if (!wel) state <= ST_HOLD;
                  end
                  default: state <= ST_HOLD;
                endcase
              end else if (cnt == CW'(FLEN)) begin
                state <= ST_HOLD;
                if (!wc_seen && !wc_lvl) begin
                  wr_start   <= 1'b1;
                  wr_addr    <= frame[HLEN-1:8];
                  wr_data    <= frame[FLEN-1:HLEN];
                  post_write <= 1'b1;
                end
              end
            end
          end
          ST_READ: begin
            if (sk_fall) begin
              do_oe <= 1'b1;
              if (bitpos == '0) begin
                do_val  <= rword[0];
                osh     <= rword;
                rd_addr <= rd_addr + 1'b1;
              end else begin
                do_val <= osh[bitpos];
              end
              bitpos <= (bitpos == BW'(DW - 1)) ? '0 : bitpos + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_word_mem.sv
module serial_word_mem #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdi,
  input  logic wr_ctl,
  output logic sdo,
  output logic sdo_oe,
  output logic rdy
);
  logic [3:0]    sync_lvl;
  logic          sel_s, sk_s, di_s, wc_s;
  logic          sel_q, sk_q;
  logic          sel_rise, sel_fall, sk_rise, sk_fall;
  logic [AW-1:0] rd_addr, wr_addr, mem_waddr;
  logic [DW-1:0] wr_data, mem_wdata, rword;
  logic          wr_start, mem_we, busy;
  logic          do_val, do_oe, status_on;

  swm_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0001)) sync_i (
    .clk (clk),
    .rst (rst),
    .din ({wr_ctl, sdi, sclk, sel_n}),
    .lvl (sync_lvl)
  );
  assign sel_s = sync_lvl[0];
  assign sk_s  = sync_lvl[1];
  assign di_s  = sync_lvl[2];
  assign wc_s  = sync_lvl[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b1;
      sk_q  <= 1'b0;
    end else begin
      sel_q <= sel_s;
      sk_q  <= sk_s;
    end
  end
  assign sel_rise = sel_s & ~sel_q;
  assign sel_fall = ~sel_s & sel_q;
  assign sk_rise  = sk_s & ~sk_q;
  assign sk_fall  = ~sk_s & sk_q;

  swm_frame #(.AW(AW), .DW(DW)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .sk_rise   (sk_rise),
    .sk_fall   (sk_fall),
    .sel_rise  (sel_rise),
    .sel_fall  (sel_fall),
    .sk_lvl    (sk_s),
    .di_lvl    (di_s),
    .wc_lvl    (wc_s),
    .busy      (busy),
    .rword     (rword),
    .rd_addr   (rd_addr),
    .wr_start  (wr_start),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .do_val    (do_val),
    .do_oe     (do_oe),
    .status_on (status_on)
  );

  swm_prog_timer #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (wr_start),
    .abort (wc_s),
    .addr  (wr_addr),
    .data  (wr_data),
    .busy  (busy),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata)
  );

  swm_store #(.AW(AW), .DW(DW)) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rword (rword)
  );

  assign sdo    = status_on ? ~busy : do_val;
  assign sdo_oe = status_on | do_oe;
  assign rdy    = ~busy;
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy,
  input logic          busy,
  input logic          wc_s,
  input logic          wr_start,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          sel_rise,
  input logic          oe
);
  assert_ready_falls_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> $past(wr_start));

  assert_write_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(busy) && !busy));

  assert_no_start_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_start);

  assert_abort_marker_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && wc_s) |=> (mem_we && mem_wdata == '0));

  assert_release_tristate_R3: assert property (@(posedge clk) disable iff (rst)
    sel_rise |=> !oe);
endmodule

bind serial_word_mem swm_checker #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rdy       (rdy),
  .busy      (busy),
  .wc_s      (wc_s),
  .wr_start  (wr_start),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .sel_rise  (sel_rise),
  .oe        (sdo_oe)
);

// File: tb/serial_word_mem_tb_top.sv
module serial_word_mem_tb_top;
  localparam int PROG = 600;
  localparam int HALF = 5;
  localparam logic [3:0] SP = 4'b1010;
  localparam logic [3:0] RD = 4'b1000;
  localparam logic [3:0] WR = 4'b0100;
  localparam logic [3:0] EN = 4'b0011;
  localparam logic [3:0] DS = 4'b0000;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, wr_ctl = 1'b0;
  logic sdo, sdo_oe, rdy;

  always #4 clk = ~clk;

  serial_word_mem #(.AW(8), .DW(16), .PROG_CYCLES(PROG)) dut_i (
    .clk (clk), .rst (rst), .sel_n (sel_n), .sclk (sclk), .sdi (sdi),
    .wr_ctl (wr_ctl), .sdo (sdo), .sdo_oe (sdo_oe), .rdy (rdy)
  );

  int total = 0, bad = 0;
  logic [15:0] model [256];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          mon_on = 1'b0;
  logic [15:0] mon_word;
  int          mon_n = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: collects read bits at each host rising edge and scores words.
  always @(posedge sclk) begin
    logic [15:0] e;
    string t;
    if (mon_on) begin
      if (sdo_oe !== 1'b1) check(1'b0, "R3 sdo_oe during read", {31'b0, sdo_oe}, 32'd1);
      mon_word[mon_n] = sdo;
      mon_n++;
      if (mon_n == 16) begin
        mon_n = 0;
        if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", {16'b0, mon_word}, 32'd0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mon_word === e, t, {16'b0, mon_word}, {16'b0, e});
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b0; sdi = b; tick(HALF);
    sclk = 1'b1; tick(HALF);
  endtask

  task automatic sel_low();
    sclk = 1'b0; tick(HALF);
    sel_n = 1'b0; tick(HALF);
  endtask

  task automatic sel_high();
    sclk = 1'b0; tick(HALF);
    sel_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic hdr(input logic [3:0] st, input logic [3:0] op, input logic [7:0] a);
    for (int i = 3; i >= 0; i--) bit_out(st[i]);
    for (int i = 3; i >= 0; i--) bit_out(op[i]);
    for (int i = 0; i < 8; i++) bit_out(a[i]);
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [15:0] d);
    sel_low();
    hdr(SP, WR, a);
    for (int i = 0; i < 16; i++) bit_out(d[i]);
  endtask

  task automatic cmd(input logic [3:0] op, input int extra);
    sel_low();
    hdr(SP, op, 8'h5A);
    repeat (extra) bit_out(1'b1);
    sel_high();
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (rdy !== 1'b1 && n < 20000) begin
      tick(1);
      n++;
    end
  endtask

  // Driver: pushes the expected words, then clocks the read out.
  task automatic rd(input logic [7:0] a, input int nw, input string tag);
    for (int i = 0; i < nw; i++) begin
      exp_q.push_back(model[8'(a + i)]);
      tag_q.push_back(tag);
    end
    sel_low();
    hdr(SP, RD, a);
    check(sdo_oe === 1'b0, "R3 hi-z through 16th clock", {31'b0, sdo_oe}, 32'd0);
    mon_on = 1'b1;
    repeat (16 * nw) bit_out(1'b0);
    mon_on = 1'b0;
    sel_high();
  endtask

  initial begin
    int n;
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    tick(5);
    rst = 1'b0;
    tick(10);

    check(rdy === 1'b1, "R1 rdy after reset", {31'b0, rdy}, 32'd1);
    check(sdo_oe === 1'b0, "R1 sdo_oe after reset", {31'b0, sdo_oe}, 32'd0);
    rd(8'h00, 2, "R1 erased words");

    // R5: write with latch clear
    wr_frame(8'h10, 16'hDEAD);
    sel_high();
    check(rdy === 1'b1, "R5 no busy without WEN", {31'b0, rdy}, 32'd1);
    rd(8'h10, 1, "R5 word unchanged");

    // R2: enable with a bad start pattern does nothing
    sel_low();
    hdr(4'b1110, EN, 8'h00);
    sel_high();
    wr_frame(8'h11, 16'h1234);
    sel_high();
    check(rdy === 1'b1, "R2 bad start ignored", {31'b0, rdy}, 32'd1);
    rd(8'h11, 1, "R2 word unchanged");

    // R6: enable with wr_ctl high and extra clocks; R7/R11 write and status
    wr_ctl = 1'b1;
    cmd(EN, 20);
    wr_ctl = 1'b0;
    tick(HALF);
    wr_frame(8'h20, 16'hA5C3);
    model[8'h20] = 16'hA5C3;
    sclk = 1'b0; tick(HALF);
    check(rdy === 1'b0, "R7 busy after 32nd clock", {31'b0, rdy}, 32'd0);
    sel_n = 1'b1; tick(2 * HALF);
    sel_n = 1'b0; tick(HALF);
    check(sdo_oe === 1'b1 && sdo === 1'b0, "R11 status busy on sdo", {30'b0, sdo_oe, sdo}, 32'd2);
    wait_ready(n);
    n = n + 5 * HALF;
    check(n >= PROG && n <= PROG + 12, "R7 program cycle length", n, PROG);
    tick(2);
    check(sdo_oe === 1'b1 && sdo === 1'b1, "R11 status ready on sdo", {30'b0, sdo_oe, sdo}, 32'd3);
    sel_n = 1'b1; tick(2 * HALF);
    check(sdo_oe === 1'b0, "R11 status released", {31'b0, sdo_oe}, 32'd0);

    rd(8'h1F, 3, "R4 R7 sequential read");

    wr_frame(8'hFF, 16'h7E81);
    model[8'hFF] = 16'h7E81;
    sel_high();
    wait_ready(n);
    rd(8'hFF, 2, "R4 address wrap");

    // R8: cancel by select
    sel_low();
    hdr(SP, WR, 8'h30);
    for (int i = 0; i < 8; i++) bit_out(1'b0);
    sel_high();
    check(rdy === 1'b1, "R8 select cancel no busy", {31'b0, rdy}, 32'd1);
    rd(8'h30, 1, "R8 select cancel word");

    // R8: cancel by wr_ctl pulse
    sel_low();
    hdr(SP, WR, 8'h31);
    for (int i = 0; i < 8; i++) bit_out(1'b0);
    wr_ctl = 1'b1;
    bit_out(1'b0);
    wr_ctl = 1'b0;
    for (int i = 0; i < 7; i++) bit_out(1'b0);
    sel_high();
    check(rdy === 1'b1, "R8 wr_ctl cancel no busy", {31'b0, rdy}, 32'd1);
    rd(8'h31, 1, "R8 wr_ctl cancel word");

    // R9: abort during busy
    wr_frame(8'h40, 16'h1357);
    sel_high();
    tick(50);
    check(rdy === 1'b0, "R9 busy before abort", {31'b0, rdy}, 32'd0);
    wr_ctl = 1'b1; tick(6);
    wr_ctl = 1'b0;
    check(rdy === 1'b1, "R9 ready after abort", {31'b0, rdy}, 32'd1);
    model[8'h40] = 16'h0000;
    rd(8'h40, 1, "R9 aborted word marker");

    // R10: frame during busy ignored
    wr_frame(8'h50, 16'hBEEF);
    model[8'h50] = 16'hBEEF;
    sel_high();
    wr_frame(8'h51, 16'h1111);
    sel_high();
    check(rdy === 1'b0, "R10 still busy after second frame", {31'b0, rdy}, 32'd0);
    wait_ready(n);
    rd(8'h50, 2, "R10 busy frame ignored");

    // R10: second instruction under the same select ignored
    sel_low();
    hdr(SP, EN, 8'h00);
    hdr(SP, WR, 8'h60);
    for (int i = 0; i < 16; i++) bit_out(1'b1);
    sel_high();
    check(rdy === 1'b1, "R10 no re-arm without select high", {31'b0, rdy}, 32'd1);
    rd(8'h60, 1, "R10 word unchanged");

    // R6: disable with wr_ctl high, then write refused
    wr_ctl = 1'b1;
    cmd(DS, 0);
    wr_ctl = 1'b0;
    tick(HALF);
    wr_frame(8'h61, 16'h2222);
    sel_high();
    check(rdy === 1'b1, "R6 WDS clears latch", {31'b0, rdy}, 32'd1);
    rd(8'h61, 1, "R6 R5 word after WDS");

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 run did not finish act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule